// File: doc/BRIEF.md
# Addressable Latch With Demultiplexer Mode

This block keeps a small bank of single-bit storage cells that are written one at a time through a binary address and one data input. Two active-low control inputs, a write enable and a clear, together choose one of four behaviours. The block can write the addressed cell, hold every cell, steer the data input to one output while forcing the other outputs low, or clear everything. It suits scattered control bits that software or a sequencer sets one by one, and strobe fan-out where a single pulse must reach exactly one of several destinations.

The design is fully synchronous. Mode, address and data are sampled on the rising clock edge. Both the storage cells and the outputs are flip-flops, so every change shows at the outputs one cycle after the inputs that caused it. Storage and outputs are kept apart. In the steering mode the outputs show a decode of address and data, while the stored bits stay untouched. They show again at the outputs as soon as the block returns to hold or write. A separate asynchronous active-low power-on reset clears storage and outputs at once.

Top module: `addr_latch_demux`

## Requirements
- R1: With `wr_n` low and `clr_n` high (write mode), a rising edge stores `din` into the cell picked by `sel`, and all other cells keep their values. After that same edge, `q` equals the updated storage.
- R2: With `wr_n` high and `clr_n` high (hold mode), storage does not change whatever `sel` and `din` do. After the edge, `q` equals the stored contents.
- R3: With `wr_n` low and `clr_n` low (steer mode), after the edge the output bit picked by `sel` equals `din`, and every other output bit is 0.
- R4: With `wr_n` high and `clr_n` low (clear mode), after the edge all storage cells and all output bits are 0, whatever `sel` and `din` are.
- R5: Steer mode leaves storage untouched. The first hold or write edge after steer mode shows the stored contents again on `q`.
- R6: `sel` is plain binary with bit 0 as the least significant bit. Value k picks cell k and output bit `q[k]`, for k from 0 to NUM_OUT-1.
- R7: While `rst_n` is low, storage and `q` are 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sel | input | ADDR_W (3) | Binary cell address, bit 0 least significant |
| din | input | 1 | Data bit to store or steer |
| wr_n | input | 1 | Active-low write enable, one of the two mode controls |
| clr_n | input | 1 | Active-low clear, one of the two mode controls |
| q | output | NUM_OUT (8) | Registered outputs, bit k tied to cell k |

## Verification
Some properties are checked on every cycle. Hold and steer modes leave storage unchanged. A write edge changes at most one storage bit. Steer mode produces at most one high output. Clear mode leaves both storage and outputs at zero. The address decoder always produces exactly one hit. Other behaviour can only be shown by the bench's scenarios: that the written bit lands at the binary position of `sel`, that the stored pattern comes back after a steer episode, and that the asynchronous reset clears the outputs between clock edges. The bench covers these with a behavioural reference model, all addresses in every mode, and every ordered pair of modes.

// File: rtl/alatch_pkg.sv
package alatch_pkg;

   typedef enum logic [1:0] {
      MODE_WRITE = 2'd0,
      MODE_HOLD  = 2'd1,
      MODE_STEER = 2'd2,
      MODE_CLEAR = 2'd3
   } mode_t;

   // Maps the two active-low controls onto a mode.
   function automatic mode_t decode_mode(input logic wr_n, input logic clr_n);
      case ({wr_n, clr_n})
         2'b01:   return MODE_WRITE;
         2'b11:   return MODE_HOLD;
         2'b00:   return MODE_STEER;
         default: return MODE_CLEAR;
      endcase
   endfunction

endpackage

// File: rtl/alatch_mode_dec.sv
module alatch_mode_dec
   import alatch_pkg::*;
(
   input  logic  wr_n,
   input  logic  clr_n,
   output mode_t mode
);

   always_comb mode = decode_mode(wr_n, clr_n);

endmodule

// File: rtl/alatch_addr_dec.sv
module alatch_addr_dec #(
   parameter int ADDR_W  = 3,
   parameter int NUM_OUT = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0]  sel,
   output logic [NUM_OUT-1:0] hit
);

   // One comparator per output; binary order, bit 0 of sel least significant (R6)
   for (genvar k = 0; k < NUM_OUT; k++) begin : g_hit
      assign hit[k] = (sel == ADDR_W'(k));
   end

   always_comb begin
      assert_decode_onehot_R6: assert ($onehot(hit) || $isunknown(sel));
   end

endmodule

// File: rtl/alatch_cell_bank.sv
module alatch_cell_bank
   import alatch_pkg::*;
#(
   parameter int NUM_OUT = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  mode_t              mode,
   input  logic [NUM_OUT-1:0] hit,
   input  logic               din,
   output logic [NUM_OUT-1:0] store,
   output logic [NUM_OUT-1:0] q
);

   for (genvar k = 0; k < NUM_OUT; k++) begin : g_cell
      logic store_nx;
      logic q_nx;

      always_comb begin
         store_nx = store[k];
         unique case (mode)
            MODE_WRITE: if (hit[k]) store_nx = din;
            MODE_CLEAR: store_nx = 1'b0;
            default:    store_nx = store[k];
         endcase
      end

      always_comb begin
         unique case (mode)
            MODE_STEER: q_nx = hit[k] & din;
            MODE_CLEAR: q_nx = 1'b0;
            default:    q_nx = store_nx;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            store[k] <= 1'b0;
            q[k]     <= 1'b0;
         end else begin
            store[k] <= store_nx;
            q[k]     <= q_nx;
         end
      end
   end

endmodule

// File: rtl/addr_latch_demux.sv
module addr_latch_demux
   import alatch_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int NUM_OUT = 1 << ADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  sel,
   input  logic               din,
   input  logic               wr_n,
   input  logic               clr_n,
   output logic [NUM_OUT-1:0] q
);

   localparam int FULL_SPAN = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_width
      $error("addr_latch_demux: ADDR_W must be 1..6");
   end
   if (NUM_OUT != FULL_SPAN) begin : g_bad_count
      $error("addr_latch_demux: NUM_OUT must equal 2**ADDR_W");
   end

   mode_t              mode;
   logic [NUM_OUT-1:0] hit;
   logic [NUM_OUT-1:0] store;

   alatch_mode_dec u_mode (
      .wr_n  (wr_n),
      .clr_n (clr_n),
      .mode  (mode)
   );

   alatch_addr_dec #(
      .ADDR_W  (ADDR_W),
      .NUM_OUT (NUM_OUT)
   ) u_addr (
      .sel (sel),
      .hit (hit)
   );

   alatch_cell_bank #(
      .NUM_OUT (NUM_OUT)
   ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode),
      .hit   (hit),
      .din   (din),
      .store (store),
      .q     (q)
   );

   // A write edge touches at most one storage bit
   assert_single_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_WRITE |=> $countones(store ^ $past(store)) <= 1);

   // Hold mode never alters storage
   assert_hold_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_HOLD |=> $stable(store));

   // Steer mode raises at most one output
   assert_steer_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_STEER |=> $onehot0(q));

   // Clear mode empties storage and outputs
   assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_CLEAR |=> (q == '0 && store == '0));

   // Steer mode keeps storage intact
   assert_steer_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_STEER |=> $stable(store));

   // Outputs follow storage after a hold edge
   assert_hold_shows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_HOLD |=> q == store);

endmodule

// File: tb/addr_latch_demux_test.sv
module addr_latch_demux_test;

   localparam int AW = 3;
   localparam int NQ = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] sel = '0;
   logic          din = 1'b0;
   logic          wr_n = 1'b1;
   logic          clr_n = 1'b1;
   logic [NQ-1:0] q;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   bit m_store [NQ];
   bit m_q     [NQ];

   addr_latch_demux #(.ADDR_W(AW), .NUM_OUT(NQ)) uut (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (sel),
      .din   (din),
      .wr_n  (wr_n),
      .clr_n (clr_n),
      .q     (q)
   );

   always #4 clk = ~clk;

   function automatic logic [NQ-1:0] model_q();
      logic [NQ-1:0] v;
      for (int k = 0; k < NQ; k++) v[k] = m_q[k];
      return v;
   endfunction

   function automatic string tag_of(input logic w, input logic c);
      case ({w, c})
         2'b01:   return "R1 R6";
         2'b11:   return "R2";
         2'b00:   return "R3 R6";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input string tag);
      logic [NQ-1:0] exp_v;
      exp_v = model_q();
      n_vec++;
      if (q !== exp_v) begin
         n_bad++;
         $display("FAIL %s: q=%b expected %b at %0t", tag, q, exp_v, $time);
      end
   endtask

   // Drive at the falling edge, let one rising edge pass, compare at the next falling edge
   task automatic step(input logic w, input logic c, input int a, input logic d, input string tag);
      wr_n  = w;
      clr_n = c;
      sel   = a[AW-1:0];
      din   = d;
      @(posedge clk);
      case ({w, c})
         2'b01: begin
            m_store[a] = d;
            for (int k = 0; k < NQ; k++) m_q[k] = m_store[k];
         end
         2'b11: for (int k = 0; k < NQ; k++) m_q[k] = m_store[k];
         2'b00: begin
            for (int k = 0; k < NQ; k++) m_q[k] = 1'b0;
            m_q[a] = d;
         end
         default: for (int k = 0; k < NQ; k++) begin
            m_store[k] = 1'b0;
            m_q[k]     = 1'b0;
         end
      endcase
      @(negedge clk);
      check(tag);
   endtask

   task automatic model_reset();
      for (int k = 0; k < NQ; k++) begin
         m_store[k] = 1'b0;
         m_q[k]     = 1'b0;
      end
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      check("R7");  // reset state
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R6: write a pattern to every address
      for (int a = 0; a < NQ; a++) step(1'b0, 1'b1, a, logic'(a[0] ^ a[2]), "R1 R6");
      // R2: hold while address and data wander
      for (int a = 0; a < NQ; a++) step(1'b1, 1'b1, 7 - a, logic'(~a[0]), "R2");
      // R3: steer every address with both data values
      for (int a = 0; a < NQ; a++) begin
         step(1'b0, 1'b0, a, 1'b1, "R3 R6");
         step(1'b0, 1'b0, a, 1'b0, "R3");
      end
      // R5: stored pattern returns after steering
      step(1'b1, 1'b1, 3, 1'b1, "R5");
      step(1'b0, 1'b0, 5, 1'b1, "R3");
      step(1'b0, 1'b1, 1, 1'b1, "R5");
      // R4: clear at every address
      for (int a = 0; a < NQ; a++) step(1'b1, 1'b0, a, 1'b1, "R4");
      step(1'b1, 1'b1, 2, 1'b1, "R4");
      // R1: walking one and overwrite
      for (int a = 0; a < NQ; a++) step(1'b0, 1'b1, a, 1'b1, "R1 R6");
      step(1'b0, 1'b1, 6, 1'b0, "R1");
      step(1'b0, 1'b1, 6, 1'b1, "R1");
      // every ordered pair of modes, random address and data
      for (int p = 0; p < 4; p++) begin
         for (int n = 0; n < 4; n++) begin
            for (int r = 0; r < 4; r++) begin
               logic pw, pc, nw, nc;
               pw = logic'(p[1]); pc = logic'(p[0]);
               nw = logic'(n[1]); nc = logic'(n[0]);
               step(pw, pc, int'($urandom_range(NQ - 1)), logic'($urandom_range(1)), tag_of(pw, pc));
               step(nw, nc, int'($urandom_range(NQ - 1)), logic'($urandom_range(1)), tag_of(nw, nc));
            end
         end
      end
      // R7: asynchronous reset between edges
      for (int a = 0; a < NQ; a++) step(1'b0, 1'b1, a, 1'b1, "R1");
      #1 rst_n = 1'b0;
      #1 model_reset();
      check("R7");
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, 1'b1, 0, 1'b1, "R7");

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule